// File: doc/BRIEF.md
# Bus Error Event Unit

The unit gathers ECC error events raised by the instruction cache, the data cache and the L2 cache. Each source presents a one-cycle valid pulse together with the physical address that faulted. An event counts only when its bit in the event enable mask is set. The first such event after the cause register was cleared records a cause code and the faulting address.

Every accepted event also sets a sticky bit in an accrued mask. Two interrupt lines are derived from that mask, each through its own enable mask. The local line goes to the owning hart as a non-maskable interrupt. The global line goes to the platform interrupt controller.

Software reaches six 64-bit registers through a plain write strobe and a combinational read port. It uses them to enable sources, to read and clear the recorded event, and to acknowledge accrued bits.

Top module: `err_event_unit`

## Requirements
- R1: After reset the cause register reads 0, accrued, local-enable and global-enable read 0, the event enable reads 0x0E, and both interrupt lines are low.
- R2: Registers sit at these byte offsets: cause 0x00, value 0x08, event enable 0x10, global enable 0x18, accrued 0x20, local enable 0x28. Offset bits [2:0] are ignored.
- R3: The four mask registers hold only bits 1 to 3, where bit n belongs to cause code n. All other mask bits read 0. The cause register holds its low 8 bits. The value register holds the low 40 bits.
- R4: Any offset from 0x30 to 0xFFF reads 0, and a write to such an offset changes no register.
- R5: A source pulse whose enable bit is clear has no effect on cause, value or accrued.
- R6: An accepted event while cause reads 0 loads cause with the source's code and value with its address. The codes are 1 for the instruction cache (source 0), 2 for the data cache (source 1) and 3 for the L2 cache (source 2). Results are readable one cycle after the pulse.
- R7: While cause is nonzero, further accepted events leave cause and value unchanged.
- R8: When several accepted events arrive in the same cycle, the lowest code is captured and every one of them sets its accrued bit.
- R9: Accrued bits stay set until software writes the accrued register. A software write and an event in the same cycle give the written value OR the event's bit.
- R10: A software write to cause in the same cycle as an accepted event takes priority, and no capture happens in that cycle.
- R11: The local interrupt line is high exactly when accrued AND local enable is nonzero. The global interrupt line follows accrued AND global enable in the same way. Both are valid from the cycle after the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcValid | input | 3 | Per-source error pulse (bit 0 instruction cache, bit 1 data cache, bit 2 L2) |
| srcAddr | input | 120 | Per-source physical address, 40 bits each, source 0 in the low bits |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Register read data for regAddr, combinational |
| intLocal | output | 1 | Hart-local non-maskable interrupt request |
| intGlobal | output | 1 | Interrupt request to the platform interrupt controller |

## Verification
Every register update lands on the clock edge after the strobe or pulse, so results are due one cycle after the stimulus. The read port is combinational, so a value can be read back in that same cycle. The interrupt lines are derived combinationally from the registers and follow on that same cycle. The bench drives all stimulus on the falling edge. It then reads back or samples the lines on the following falling edge, half a period after the update. The sweeps cover every combination of event enable and source pattern, and every combination of accrued bits and interrupt masks.

// File: rtl/err_event_pkg.sv
package err_event_pkg;
  localparam int REG_W = 64;
  localparam logic [11:0] OFF_CAUSE   = 12'h000;
  localparam logic [11:0] OFF_VALUE   = 12'h008;
  localparam logic [11:0] OFF_ENABLE  = 12'h010;
  localparam logic [11:0] OFF_GLOBAL  = 12'h018;
  localparam logic [11:0] OFF_ACCRUED = 12'h020;
  localparam logic [11:0] OFF_LOCAL   = 12'h028;

  typedef struct packed {
    logic             wrCause;
    logic             wrValue;
    logic             wrEnable;
    logic             wrGlobal;
    logic             wrAccrued;
    logic             wrLocal;
    logic             capture;
    logic [7:0]       capCode;
    logic [REG_W-1:0] acceptMask;
  } strobe_t;
endpackage

// File: rtl/err_event_ctrl.sv
module err_event_ctrl
  import err_event_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [REG_W-1:0]   enableReg,
  input  logic               causeZero,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  output strobe_t            st
);
  logic [ADDR_W-1:0] wordAddr;
  assign wordAddr = {regAddr[ADDR_W-1:3], 3'b000};

  always_comb begin
    st = '0;
    if (regWe) begin
      st.wrCause   = (wordAddr == ADDR_W'(OFF_CAUSE));
      st.wrValue   = (wordAddr == ADDR_W'(OFF_VALUE));
      st.wrEnable  = (wordAddr == ADDR_W'(OFF_ENABLE));
      st.wrGlobal  = (wordAddr == ADDR_W'(OFF_GLOBAL));
      st.wrAccrued = (wordAddr == ADDR_W'(OFF_ACCRUED));
      st.wrLocal   = (wordAddr == ADDR_W'(OFF_LOCAL));
    end
    for (int i = 0; i < NUM_SRC; i++)
      st.acceptMask[i+1] = srcValid[i] & enableReg[i+1];
    // scan downward so the lowest code wins
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (st.acceptMask[i+1]) st.capCode = 8'(i + 1);
    st.capture = (|st.acceptMask) && causeZero && !st.wrCause;
  end

  // R10
  capture_vs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrCause |-> !st.capture);

  // R8
  capture_code_accepted_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |-> (st.capCode >= 8'd1 && st.capCode <= 8'(NUM_SRC) && st.acceptMask[st.capCode[5:0]]));
endmodule

// File: rtl/err_event_regs.sv
module err_event_regs
  import err_event_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PA_W    = 40,
  parameter int ADDR_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 st,
  input  logic [NUM_SRC*PA_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [REG_W-1:0]        regWdata,
  output logic [REG_W-1:0]        regRdata,
  output logic [REG_W-1:0]        enableReg,
  output logic                    causeZero,
  output logic                    intLocal,
  output logic                    intGlobal
);
  localparam logic [REG_W-1:0] IMPL_MASK =
    ((REG_W'(1) << (NUM_SRC + 1)) - REG_W'(1)) & ~REG_W'(1);

  logic [7:0]       causeReg;
  logic [PA_W-1:0]  valueReg;
  logic [REG_W-1:0] globalReg, accruedReg, localReg;
  logic [PA_W-1:0]  capAddr;
  logic [ADDR_W-1:0] wordAddr;

  assign wordAddr  = {regAddr[ADDR_W-1:3], 3'b000};
  assign causeZero = (causeReg == 8'd0);

  always_comb begin
    capAddr = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (st.capCode == 8'(i + 1)) capAddr = srcAddr[i*PA_W +: PA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg   <= '0;
      enableReg  <= IMPL_MASK;
      globalReg  <= '0;
      accruedReg <= '0;
      localReg   <= '0;
    end else begin
      if (st.wrCause)       causeReg <= regWdata[7:0];
      else if (st.capture)  causeReg <= st.capCode;
      if (st.wrEnable) enableReg <= regWdata & IMPL_MASK;
      if (st.wrGlobal) globalReg <= regWdata & IMPL_MASK;
      if (st.wrLocal)  localReg  <= regWdata & IMPL_MASK;
      accruedReg <= (st.wrAccrued ? (regWdata & IMPL_MASK) : accruedReg) | st.acceptMask;
    end
  end

  // value register carries no reset state
  always_ff @(posedge clk) begin
    if (st.wrValue)      valueReg <= regWdata[PA_W-1:0];
    else if (st.capture) valueReg <= capAddr;
  end

  always_comb begin
    regRdata = '0;
    unique case (wordAddr)
      ADDR_W'(OFF_CAUSE):   regRdata = REG_W'(causeReg);
      ADDR_W'(OFF_VALUE):   regRdata = REG_W'(valueReg);
      ADDR_W'(OFF_ENABLE):  regRdata = enableReg;
      ADDR_W'(OFF_GLOBAL):  regRdata = globalReg;
      ADDR_W'(OFF_ACCRUED): regRdata = accruedReg;
      ADDR_W'(OFF_LOCAL):   regRdata = localReg;
      default:              regRdata = '0;
    endcase
  end

  assign intLocal  = |(accruedReg & localReg);
  assign intGlobal = |(accruedReg & globalReg);

  // R7
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!causeZero && !st.wrCause) |=> causeReg == $past(causeReg));

  // R7
  value_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!causeZero && !st.wrCause && !st.wrValue) |=> valueReg == $past(valueReg));

  // R9
  accrued_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrAccrued |=> (accruedReg & $past(accruedReg)) == $past(accruedReg));

  // R5
  accrued_enabled_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.wrAccrued && !st.wrEnable) |=> ((accruedReg & ~$past(accruedReg) & ~enableReg) == '0));

  // R3
  mask_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((accruedReg | localReg | globalReg | enableReg) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/err_event_unit.sv
module err_event_unit
  import err_event_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int PA_W    = 40,
  parameter int ADDR_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_SRC-1:0]      srcValid,
  input  logic [NUM_SRC*PA_W-1:0] srcAddr,
  input  logic                    regWe,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [REG_W-1:0]        regWdata,
  output logic [REG_W-1:0]        regRdata,
  output logic                    intLocal,
  output logic                    intGlobal
);
  strobe_t          st;
  logic [REG_W-1:0] enableReg;
  logic             causeZero;

  err_event_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .enableReg(enableReg),
    .causeZero(causeZero), .regWe(regWe), .regAddr(regAddr), .st(st)
  );

  err_event_regs #(.NUM_SRC(NUM_SRC), .PA_W(PA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .st(st), .srcAddr(srcAddr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .enableReg(enableReg),
    .causeZero(causeZero), .intLocal(intLocal), .intGlobal(intGlobal)
  );
endmodule

// File: tb/err_event_unit_tb.sv
module err_event_unit_tb;
  localparam int NUM_SRC = 3;
  localparam int PA_W = 40;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [NUM_SRC-1:0]      srcValid = '0;
  logic [NUM_SRC*PA_W-1:0] srcAddr = '0;
  logic                    regWe = 1'b0;
  logic [11:0]             regAddr = '0;
  logic [63:0]             regWdata = '0;
  logic [63:0]             regRdata;
  logic                    intLocal, intGlobal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  err_event_unit u_dut (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcAddr(srcAddr),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .intLocal(intLocal), .intGlobal(intGlobal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [39:0] addrOf(input int i, input int tag);
    return 40'h80_0000_0000 + 40'(i) * 40'h100 + 40'(tag) * 40'h1_0000;
  endfunction

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(12'h000, d); chk("R1 cause", d, 64'h0);
    rd(12'h010, d); chk("R1 enable", d, 64'h0E);
    rd(12'h018, d); chk("R1 global", d, 64'h0);
    rd(12'h020, d); chk("R1 accrued", d, 64'h0);
    rd(12'h028, d); chk("R1 local", d, 64'h0);
    chk("R1 intLocal", 64'(intLocal), 64'h0);
    chk("R1 intGlobal", 64'(intGlobal), 64'h0);

    // R2, R3 offsets and implemented bits
    wr(12'h018, '1); rd(12'h01C, d); chk("R2 R3 global", d, 64'h0E);
    wr(12'h028, '1); rd(12'h02F, d); chk("R2 R3 local", d, 64'h0E);
    wr(12'h020, '1); rd(12'h020, d); chk("R3 accrued", d, 64'h0E);
    wr(12'h008, 64'hFFFF_FF12_3456_789A); rd(12'h00B, d); chk("R2 R3 value", d, 64'h12_3456_789A);
    wr(12'h000, 64'h1_2345); rd(12'h000, d); chk("R3 cause", d, 64'h45);
    // R4 unmapped offsets
    for (int a = 12'h030; a <= 12'hFF8; a += 12'h1C8) begin
      wr(12'(a), '1); rd(12'(a), d); chk("R4 unmapped read", d, 64'h0);
    end
    rd(12'h000, d); chk("R4 cause untouched", d, 64'h45);
    rd(12'h010, d); chk("R4 enable untouched", d, 64'h0E);
    wr(12'h018, 0); wr(12'h028, 0);

    // R5 R6 R8 sweep over enable x source pattern
    for (int en = 0; en < 8; en++) begin
      for (int src = 0; src < 8; src++) begin
        int m, code;
        logic [39:0] expAddr;
        wr(12'h020, 0); wr(12'h000, 0); wr(12'h008, 64'h55);
        wr(12'h010, 64'(en) << 1);
        @(negedge clk);
        srcValid = 3'(src);
        srcAddr = {addrOf(2, src), addrOf(1, en), addrOf(0, en + src)};
        @(negedge clk);
        srcValid = '0;
        m = src & en;
        code = m[0] ? 1 : m[1] ? 2 : m[2] ? 3 : 0;
        expAddr = (code == 1) ? addrOf(0, en + src) : (code == 2) ? addrOf(1, en) :
                  (code == 3) ? addrOf(2, src) : 40'h55;
        rd(12'h020, d); chk("R5 R8 accrued", d, 64'(m) << 1);
        rd(12'h000, d); chk("R5 R6 R8 cause", d, 64'(code));
        rd(12'h008, d); chk("R5 R6 value", d, 64'(expAddr));
      end
    end

    // R7 later events do not overwrite
    wr(12'h010, 64'h0E); wr(12'h020, 0); wr(12'h000, 0);
    @(negedge clk); srcValid = 3'b100; srcAddr = {addrOf(2, 7), addrOf(1, 7), addrOf(0, 7)};
    @(negedge clk); srcValid = 3'b001; srcAddr = {addrOf(2, 9), addrOf(1, 9), addrOf(0, 9)};
    @(negedge clk); srcValid = '0;
    rd(12'h000, d); chk("R7 cause held", d, 64'h3);
    rd(12'h008, d); chk("R7 value held", d, 64'(addrOf(2, 7)));
    rd(12'h020, d); chk("R7 R9 accrued", d, 64'h0A);
    // R9 sticky across idle cycles
    repeat (5) @(negedge clk);
    rd(12'h020, d); chk("R9 sticky", d, 64'h0A);
    // R9 write with concurrent event
    regWe = 1'b1; regAddr = 12'h020; regWdata = 64'h0; srcValid = 3'b010;
    @(negedge clk); regWe = 1'b0; srcValid = '0;
    rd(12'h020, d); chk("R9 write or event", d, 64'h04);
    // R10 cause write beats capture
    wr(12'h000, 0);
    @(negedge clk);
    regWe = 1'b1; regAddr = 12'h000; regWdata = 64'h7; srcValid = 3'b001;
    @(negedge clk); regWe = 1'b0; srcValid = '0;
    rd(12'h000, d); chk("R10 cause write wins", d, 64'h7);
    rd(12'h020, d); chk("R10 accrued still set", d, 64'h06);

    // R11 interrupt sweep
    for (int acc = 0; acc < 8; acc++) begin
      for (int msk = 0; msk < 8; msk++) begin
        wr(12'h020, 64'(acc) << 1);
        wr(12'h028, 64'(msk) << 1);
        wr(12'h018, 64'((~msk) & 7) << 1);
        chk("R11 intLocal", 64'(intLocal), 64'((acc & msk) != 0));
        chk("R11 intGlobal", 64'(intGlobal), 64'((acc & ~msk & 7) != 0));
      end
    end
    // R11 event raises interrupt the cycle after
    wr(12'h020, 0); wr(12'h028, 64'h08); wr(12'h018, 0);
    chk("R11 local idle", 64'(intLocal), 64'h0);
    @(negedge clk); srcValid = 3'b100;
    @(negedge clk); srcValid = '0;
    chk("R11 local after event", 64'(intLocal), 64'h1);
    chk("R11 global masked", 64'(intGlobal), 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule